// File: doc/BRIEF.md
# Dual-Section Byte-Lane Parity Word Memory

This block is a standalone synchronous memory slice made of two equal sections, each holding 2K words of 36 bits, for 4K words in total. A word carries 32 data bits and 4 parity bits, one parity bit per byte lane. The block only stores parity. It never computes or checks it, so whatever parity logic sits upstream gets its bits back exactly as written.

Both sections hang off one write bus: write clock, 11-bit write address, 36-bit write data and four active-low byte-lane enables. A separate active-high chip select per section decides which sections take the write, so one, both or neither can be written in a cycle. The read side runs on its own clock. It has an 11-bit read address and a section select, and it returns one section's word through a registered output. That output is cleared by an asynchronous active-low reset. The storage itself is never reset.

Top module: `dsram_slice`

## Requirements
- R1: A word written with all lanes enabled reads back as the same 36 bits, with data in bits 31:0 and parity in bits 35:32, unchanged.
- R2: Byte enables are active low. Enable lane i (i = 0..3) writes data bits 8i+7 to 8i and parity bit 32+i, and only those bits.
- R3: Bits of lanes whose enable is 1 keep their previous contents, parity bit included.
- R4: A section is written only while its chip select is 1. A write with that section's select at 0 leaves that section's word unchanged.
- R5: With both chip selects at 1, both sections take the same data under the same lane mask at the same address.
- R6: Section select 0 reads section A (chip select `wcs_a`) and 1 reads section B (chip select `wcs_b`).
- R7: The read address and section select sampled on a read clock rising edge appear on `rdata` right after that edge, and stay there until the next edge.
- R8: `rrst_n` low clears `rdata` to zero at once, without a clock. Stored words survive the reset.
- R9: When a read and a write to the same section and address share one clock edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wdata | input | 36 | Write word: parity 35:32, data 31:0 |
| waddr | input | 11 | Write address, shared by both sections |
| wbyte_n | input | 4 | Active-low byte-lane write enables |
| wcs_a | input | 1 | Write chip select for section A, active high |
| wcs_b | input | 1 | Write chip select for section B, active high |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Asynchronous active-low reset of the read output register |
| raddr | input | 11 | Read address |
| rsect | input | 1 | Read section select: 0 = A, 1 = B |
| rdata | output | 36 | Registered read word |

## Verification
The hardest case to reach from the ports is a read and a write to the same word on the same clock edge, because the old-data result (R9) only shows if the read lands in exactly that cycle. The bench runs both clocks in phase. Random addresses are drawn from a small window, so collisions happen often, and a directed case forces one. A reference model updated only after each cycle's expected value is taken then predicts old-before-new. Lane isolation is reached by writing all-ones through single-lane masks over words that are known to be zero.

// File: rtl/dsram_pkg.sv
`timescale 1ns/1ps
package dsram_pkg;

    // Bits per data byte lane; each lane also owns one parity bit.
    localparam int BYTE_W  = 8;
    // Number of sections in a slice.
    localparam int NSECT   = 2;

    typedef enum logic {
        SECT_A = 1'b0,
        SECT_B = 1'b1
    } sect_e;

    // Bit mask of every word bit owned by one lane: data byte plus parity bit.
    // Parity of lane l sits at bit lanes*BYTE_W + l (R2).
    function automatic logic [63:0] lane_bits(input int lanes, input int l);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < BYTE_W; b++) begin
            m[l*BYTE_W + b] = 1'b1;
        end
        m[lanes*BYTE_W + l] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dsram_lane_dec.sv
`timescale 1ns/1ps
// Turns the active-low shared lane enables and the per-section chip selects
// into one active-high lane strobe vector per section.
module dsram_lane_dec #(
    parameter int LANES = 4,
    parameter int NSECT = 2
) (
    input  logic [LANES-1:0]            byte_n,
    input  logic [NSECT-1:0]            cs,
    output logic [NSECT-1:0][LANES-1:0] lane_we
);

    typedef struct packed {
        logic [NSECT-1:0][LANES-1:0] we;
    } dec_t;

    dec_t dec_d;

    always_comb begin
        dec_d = '0;
        for (int s = 0; s < NSECT; s++) begin
            // R4: a section sees strobes only while its select is high.
            // R5: every selected section sees the identical mask.
            dec_d.we[s] = cs[s] ? ~byte_n : '0;
        end
    end

    assign lane_we = dec_d.we;

endmodule

// File: rtl/dsram_section.sv
`timescale 1ns/1ps
// One memory section: byte-lane merge write on the write clock, plain
// asynchronous array read that the read stage registers.
module dsram_section #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 4
) (
    input  logic               clk,
    input  logic               rst_n,   // read-domain reset, used to gate checks only
    input  logic [LANES-1:0]   lane_we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [LANES*9-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [LANES*9-1:0] rword
);
    import dsram_pkg::*;

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int WORD_W = DATA_W + LANES;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] word;
    } wr_t;

    logic [WORD_W-1:0] mem [DEPTH];
    wr_t               wr_d;

    always_comb begin
        logic [63:0] lb;
        wr_d      = '0;
        wr_d.en   = |lane_we;
        for (int l = 0; l < LANES; l++) begin
            lb = lane_bits(LANES, l);
            if (lane_we[l]) begin
                wr_d.mask = wr_d.mask | lb[WORD_W-1:0];
            end
        end
        // R2/R3: enabled lanes take new bits, the rest keep stored bits.
        wr_d.word = (wdata & wr_d.mask) | (mem[waddr] & ~wr_d.mask);
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem[waddr] <= wr_d.word;
        end
    end

    // R9: the array is read before this edge's write settles, so a read
    // registered on a coincident edge captures the old word.
    assign rword = mem[raddr];

    // ---------------- checks ----------------
    logic [ADDR_W-1:0] chk_addr_q;
    logic [WORD_W-1:0] chk_old_q;
    logic [WORD_W-1:0] chk_new_q;
    logic [WORD_W-1:0] chk_mask_q;

    always_ff @(posedge clk) begin
        chk_addr_q <= waddr;
        chk_old_q  <= mem[waddr];
        chk_new_q  <= wdata;
        chk_mask_q <= wr_d.mask;
    end

    AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[chk_addr_q] & chk_mask_q) === (chk_new_q & chk_mask_q)); // R2

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[chk_addr_q] & ~chk_mask_q) === (chk_old_q & ~chk_mask_q)); // R3

endmodule

// File: rtl/dsram_rd_stage.sv
`timescale 1ns/1ps
// Selects one section's word and holds it in the output register.
module dsram_rd_stage #(
    parameter int WORD_W = 36,
    parameter int NSECT  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sel,
    input  logic [NSECT-1:0][WORD_W-1:0] words,
    output logic [WORD_W-1:0]            rdata
);
    import dsram_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    sect_e sect;

    always_comb begin
        sect    = sect_e'(sel);
        rd_d    = rd_q;
        // R6: 0 picks section A, 1 picks section B.
        rd_d.data = (sect == SECT_B) ? words[1] : words[0];
    end

    // R7/R8: one register stage, asynchronously cleared.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;

    AST_RD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rdata === $past(sel ? words[1] : words[0])); // R7

    AST_RST_ZERO: assert property (@(posedge clk)
        $rose(rst_n) |-> rdata == '0); // R8

endmodule

// File: rtl/dsram_slice.sv
`timescale 1ns/1ps
// Two-section memory slice: shared write bus, per-section write select,
// single registered read port choosing one section.
module dsram_slice #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 4
) (
    input  logic                 wclk,
    input  logic [LANES*9-1:0]   wdata,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [LANES-1:0]     wbyte_n,
    input  logic                 wcs_a,
    input  logic                 wcs_b,
    input  logic                 rclk,
    input  logic                 rrst_n,
    input  logic [ADDR_W-1:0]    raddr,
    input  logic                 rsect,
    output logic [LANES*9-1:0]   rdata
);
    import dsram_pkg::*;

    localparam int WORD_W = LANES * (BYTE_W + 1);

    logic [NSECT-1:0][LANES-1:0]  lane_we;
    logic [NSECT-1:0][WORD_W-1:0] words;
    logic [NSECT-1:0]             cs;

    assign cs = {wcs_b, wcs_a};

    dsram_lane_dec #(
        .LANES (LANES),
        .NSECT (NSECT)
    ) u_dec (
        .byte_n  (wbyte_n),
        .cs      (cs),
        .lane_we (lane_we)
    );

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        dsram_section #(
            .ADDR_W (ADDR_W),
            .LANES  (LANES)
        ) u_sec (
            .clk     (wclk),
            .rst_n   (rrst_n),
            .lane_we (lane_we[s]),
            .waddr   (waddr),
            .wdata   (wdata),
            .raddr   (raddr),
            .rword   (words[s])
        );
    end

    dsram_rd_stage #(
        .WORD_W (WORD_W),
        .NSECT  (NSECT)
    ) u_rd (
        .clk   (rclk),
        .rst_n (rrst_n),
        .sel   (rsect),
        .words (words),
        .rdata (rdata)
    );

endmodule

// File: tb/dsram_slice_tb.sv
`timescale 1ns/1ps
module dsram_slice_tb;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic [35:0] wdata = '0;
    logic [AW-1:0] waddr = '0;
    logic [3:0]  wbyte_n = 4'hF;
    logic        wcs_a = 1'b0;
    logic        wcs_b = 1'b0;
    logic        rrst_n = 1'b0;
    logic [AW-1:0] raddr = '0;
    logic        rsect = 1'b0;
    logic [35:0] rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [35:0] mdl [2][DEPTH];

    always #2.5 wclk = ~wclk;
    always #2.5 rclk = ~rclk;

    dsram_slice #(.ADDR_W(AW), .LANES(4)) u_dut (
        .wclk(wclk), .wdata(wdata), .waddr(waddr), .wbyte_n(wbyte_n),
        .wcs_a(wcs_a), .wcs_b(wcs_b), .rclk(rclk), .rrst_n(rrst_n),
        .raddr(raddr), .rsect(rsect), .rdata(rdata)
    );

    // Lane l owns data bits 8l+7..8l and parity bit 32+l; enables active low.
    function automatic logic [35:0] lane_mask(input logic [3:0] bn);
        logic [35:0] m = '0;
        for (int l = 0; l < 4; l++) begin
            if (!bn[l]) begin
                m[l*8 +: 8] = 8'hFF;
                m[32+l]     = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] bn);
        logic [35:0] m = lane_mask(bn);
        return (nw & m) | (old & ~m);
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive one cycle, check the read at the next falling edge.
    task automatic cyc(input logic [AW-1:0] wa, input logic [35:0] wd, input logic [3:0] bn,
                       input logic ca, input logic cb, input logic [AW-1:0] ra,
                       input logic rs, input bit chk, input string req);
        logic [35:0] exp;
        waddr = wa; wdata = wd; wbyte_n = bn; wcs_a = ca; wcs_b = cb;
        raddr = ra; rsect = rs;
        exp = mdl[rs][ra];          // old contents: read precedes same-edge write
        if (ca) mdl[0][wa] = merge(mdl[0][wa], wd, bn);
        if (cb) mdl[1][wa] = merge(mdl[1][wa], wd, bn);
        @(negedge wclk);
        if (chk) check(req, rdata, exp);
    endtask

    task automatic rd(input logic [AW-1:0] ra, input logic rs, input string req);
        cyc('0, '0, 4'hF, 1'b0, 1'b0, ra, rs, 1'b1, req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: output is zero while reset is held
        #1;
        check("R8 reset state", rdata, '0);
        repeat (3) @(negedge wclk);
        check("R8 reset held", rdata, '0);

        // fill both sections (memory writes proceed during read reset)
        for (int a = 0; a < DEPTH; a++) begin
            cyc(AW'(a), {$urandom, $urandom}, 4'h0, 1'b1, 1'b1, '0, 1'b0, 1'b0, "");
        end
        rrst_n = 1'b1;
        @(negedge wclk);

        // R1: full word including parity round trip
        cyc(11'd5, 36'h9_A5C3_3C5A, 4'h0, 1'b1, 1'b0, 11'd5, 1'b0, 1'b0, "");
        rd(11'd5, 1'b0, "R1 full word");
        cyc(11'd6, 36'hF_0000_0000, 4'h0, 1'b0, 1'b1, 11'd6, 1'b1, 1'b0, "");
        rd(11'd6, 1'b1, "R1 parity only");

        // R2/R3: single-lane writes of all-ones over a zero word
        for (int l = 0; l < 4; l++) begin
            cyc(11'd10, '0, 4'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
            cyc(11'd10, '1, ~(4'(1) << l), 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
            rd(11'd10, 1'b0, "R2 single lane");
            check("R3 other lanes zero", mdl[0][10] & ~lane_mask(~(4'(1) << l)), '0);
        end
        cyc(11'd11, 36'h0_1234_5678, 4'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
        cyc(11'd11, 36'hF_FFFF_FFFF, 4'b0110, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
        rd(11'd11, 1'b0, "R3 keep lanes 1,2");
        check("R3 model", mdl[0][11], 36'h9_FF34_56FF);

        // R4: select gating
        cyc(11'd20, 36'h1_1111_1111, 4'h0, 1'b1, 1'b1, '0, 1'b0, 1'b0, "");
        cyc(11'd20, 36'h2_2222_2222, 4'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
        rd(11'd20, 1'b1, "R4 B untouched");
        cyc(11'd20, 36'h3_3333_3333, 4'h0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "");
        rd(11'd20, 1'b0, "R4 no select");
        check("R4 A value", rdata, 36'h2_2222_2222);

        // R5: both selected, partial mask
        cyc(11'd30, '0, 4'h0, 1'b1, 1'b1, '0, 1'b0, 1'b0, "");
        cyc(11'd30, 36'hF_ABCD_EF01, 4'b1010, 1'b1, 1'b1, '0, 1'b0, 1'b0, "");
        rd(11'd30, 1'b0, "R5 section A");
        check("R5 A value", rdata, 36'h5_00CD_0001);
        rd(11'd30, 1'b1, "R5 section B");
        check("R5 B value", rdata, 36'h5_00CD_0001);

        // R6: select picks the section
        cyc(11'd40, 36'h0_AAAA_AAAA, 4'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
        cyc(11'd40, 36'h0_BBBB_BBBB, 4'h0, 1'b0, 1'b1, '0, 1'b0, 1'b0, "");
        rd(11'd40, 1'b0, "R6 select A");
        check("R6 A value", rdata, 36'h0_AAAA_AAAA);
        rd(11'd40, 1'b1, "R6 select B");
        check("R6 B value", rdata, 36'h0_BBBB_BBBB);

        // R7: new address does not reach output before the edge
        raddr = 11'd5; rsect = 1'b0;
        #1;
        check("R7 hold before edge", rdata, 36'h0_BBBB_BBBB);
        @(negedge wclk);
        check("R7 after edge", rdata, 36'h9_A5C3_3C5A);

        // R9: same-edge read and write returns old word, then new
        cyc(11'd50, 36'h0_0000_0050, 4'h0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "");
        cyc(11'd50, 36'hE_DEAD_BEEF, 4'h0, 1'b1, 1'b0, 11'd50, 1'b0, 1'b1, "R9 collision old");
        check("R9 old value", rdata, 36'h0_0000_0050);
        rd(11'd50, 1'b0, "R9 new after");

        // R8: asynchronous clear mid-run, storage kept
        #1 rrst_n = 1'b0;
        #0.5;
        check("R8 async clear", rdata, '0);
        @(negedge wclk);
        rrst_n = 1'b1;
        rd(11'd5, 1'b0, "R8 memory kept");

        // random traffic over a small window to force collisions
        for (int i = 0; i < 4000; i++) begin
            cyc(AW'($urandom_range(0, 15)), {$urandom, $urandom}, 4'($urandom),
                1'($urandom), 1'($urandom), AW'($urandom_range(0, 15)),
                1'($urandom), 1'b1, "R2/R3/R4/R5/R6/R9 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule